// File: doc/BRIEF.md
# System Control Register Bank

This block is a 4 KB window of 32-bit words that platform firmware reaches over a simple word-addressed request bus. Every word in the window is backed by storage and reads back the last value written to it. Four words near the bottom of the window come out of reset holding identification and configuration constants. Every other word resets to zero.

Three of those four words are status words. On every read they show two fixed bits as set. This does not change the stored value. One command word near the top of the window also acts as a trigger: writing certain codes to it sends a single-cycle system reset request or a single-cycle power-off request to the platform. The written value is still stored as ordinary data.

Each request is accepted in the cycle in which it is presented. A read returns its data one cycle after acceptance. The two lowest address bits are ignored, so any byte address selects the word that contains it.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, reads return these values:
  - byte offset 0x100 returns 0x35F20121 (stored 0x05F20121).
  - offset 0x104 returns 0x00000002.
  - offset 0x108 returns 0x35F30121 (stored 0x05F30121).
  - offset 0x10C returns 0x35F40121 (stored 0x05F40121).
- R2: After reset, every other word in the window (for example 0x000, 0x110, 0xF00, 0xFFC) reads as zero.
- R3: A write to any word is returned by later reads of that word. Address bits 1:0 are ignored on both writes and reads.
- R4: A read accepted at one clock edge drives rsp_valid high and presents rsp_rdata after the next edge. rsp_valid is low after any edge that accepted no read. req_ready is always high.
- R5: Reads of offsets 0x100, 0x108 and 0x10C return the stored word with bits 29 and 28 set (OR with 0x30000000). The stored word itself is not modified. Offset 0x104 and all other offsets are returned unaltered.
- R6: A write of exactly 0x00000001 or 0x00000002 to offset 0xF00 sets sys_reset_req high for the one cycle that follows the accepting edge.
- R7: A write of exactly 0x00000003 to offset 0xF00 sets sys_off_req high for the one cycle that follows the accepting edge.
- R8: The following raise no request, but the written value is still stored:
  - a write of any other value to 0xF00.
  - a write of 1, 2 or 3 to any other offset.
- R9: sys_reset_req and sys_off_req are never high together. Each falls after one cycle unless another qualifying write was accepted.
- R10: Asserting rst_n low clears both request outputs and rsp_valid. It also restores all reset values, including values overwritten earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_off_req | output | 1 | One-cycle power-off request |

## Verification
The bench builds the block with its default parameters:
- a 12-bit byte address, so all 1024 words are present.
- the command word at 0xF00.
- the status group at 0x100.

With these settings the bench can check the top word of the window and the command word as plain storage. It can also check the boundary between forced and unforced status words, and back-to-back command writes. Unaligned byte addresses are used to show that the low address bits play no part in word selection.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RST  = 2'd1,
    CMD_OFF  = 2'd2
  } cmd_e;

  // Reset contents of the identification and configuration group.
  function automatic logic [DATA_W-1:0] boot_value(input int unsigned word);
    case (word)
      32'h40:  boot_value = 32'h05F2_0121;
      32'h41:  boot_value = 32'h0000_0002;
      32'h42:  boot_value = 32'h05F3_0121;
      32'h43:  boot_value = 32'h05F4_0121;
      default: boot_value = '0;
    endcase
  endfunction

  // Command codes carried by a write to the command word.
  function automatic cmd_e decode_cmd(input logic [DATA_W-1:0] code);
    if (code == 32'd1 || code == 32'd2) decode_cmd = CMD_RST;
    else if (code == 32'd3)             decode_cmd = CMD_OFF;
    else                                decode_cmd = CMD_NONE;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] CMD_OFFSET  = 12'hF00,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 12'h100,
  parameter int unsigned STAT_SPAN   = 4,
  parameter logic [STAT_SPAN-1:0] STAT_FORCE = 4'b1101,
  localparam int unsigned WORD_W     = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word_idx,
  output logic              is_cmd,
  output logic              is_forced
);

  localparam logic [WORD_W-1:0] CMD_WORD  = CMD_OFFSET[ADDR_W-1:2];
  localparam logic [WORD_W-1:0] STAT_WORD = STAT_OFFSET[ADDR_W-1:2];

  logic [STAT_SPAN-1:0] stat_hit;
  logic                 unused_lo;

  assign word_idx  = addr[ADDR_W-1:2];
  assign unused_lo = ^addr[1:0];
  assign is_cmd    = (word_idx == CMD_WORD);

  for (genvar g = 0; g < STAT_SPAN; g++) begin : g_stat
    localparam logic [WORD_W-1:0] SLOT = STAT_WORD + WORD_W'(g);
    if (STAT_FORCE[g]) begin : g_on
      assign stat_hit[g] = (word_idx == SLOT);
    end else begin : g_off
      assign stat_hit[g] = 1'b0;
    end
  end

  assign is_forced = |stat_hit;

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned WORD_W = 10,
  localparam int unsigned WORDS = 2 ** WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WORD_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic ld;
    assign ld = wr_en && (wr_idx == WORD_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[g] <= boot_value(g);
      else if (ld) mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              is_cmd,
  input  logic [DATA_W-1:0] wr_data,
  output logic              reset_req,
  output logic              off_req
);

  cmd_e cmd;
  logic rst_d, off_d, rst_q, off_q;

  always_comb begin
    cmd   = (wr_fire && is_cmd) ? decode_cmd(wr_data) : CMD_NONE;
    rst_d = (cmd == CMD_RST);
    off_d = (cmd == CMD_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      off_q <= 1'b0;
    end else begin
      rst_q <= rst_d;
      off_q <= off_d;
    end
  end

  assign reset_req = rst_q;
  assign off_req   = off_q;

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] CMD_OFFSET  = 12'hF00,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 12'h100,
  parameter logic [DATA_W-1:0] STAT_MASK   = 32'h3000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sys_reset_req,
  output logic              sys_off_req
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              wr_fire, rd_fire;
  logic [WORD_W-1:0] idx;
  logic              is_cmd, is_forced;
  logic [DATA_W-1:0] stored;
  logic              rv_d, rv_q;
  logic [DATA_W-1:0] rd_d, rd_q;

  assign req_ready = 1'b1;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;

  sysctl_decode #(
    .ADDR_W     (ADDR_W),
    .CMD_OFFSET (CMD_OFFSET),
    .STAT_OFFSET(STAT_OFFSET)
  ) u_dec (
    .addr     (req_addr),
    .word_idx (idx),
    .is_cmd   (is_cmd),
    .is_forced(is_forced)
  );

  sysctl_store #(.WORD_W(WORD_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_fire),
    .wr_idx (idx),
    .wr_data(req_wdata),
    .rd_idx (idx),
    .rd_data(stored)
  );

  sysctl_cmd u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .is_cmd   (is_cmd),
    .wr_data  (req_wdata),
    .reset_req(sys_reset_req),
    .off_req  (sys_off_req)
  );

  always_comb begin
    rv_d = rd_fire;
    rd_d = rd_q;
    if (rd_fire) rd_d = stored | (is_forced ? STAT_MASK : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= rv_d;
      rd_q <= rd_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] CMD_OFFSET  = 12'hF00,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 12'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              sys_reset_req,
  input logic              sys_off_req
);

  logic cmd_wr, rd_acc, stat0_rd;
  assign cmd_wr   = req_valid && req_ready && req_write &&
                    (req_addr[ADDR_W-1:2] == CMD_OFFSET[ADDR_W-1:2]);
  assign rd_acc   = req_valid && req_ready && !req_write;
  assign stat0_rd = rd_acc && (req_addr[ADDR_W-1:2] == STAT_OFFSET[ADDR_W-1:2]);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_reset_req && sys_off_req));

  p_rst_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_req) |-> $past(cmd_wr) && ($past(req_wdata) == 32'd1 || $past(req_wdata) == 32'd2));

  p_off_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_off_req) |-> $past(cmd_wr) && ($past(req_wdata) == 32'd3));

  p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  p_rsp_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_acc));

  p_force_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat0_rd |=> (rsp_rdata[29:28] == 2'b11));

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
  .ADDR_W     (ADDR_W),
  .CMD_OFFSET (CMD_OFFSET),
  .STAT_OFFSET(STAT_OFFSET)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .sys_reset_req(sys_reset_req),
  .sys_off_req  (sys_off_req)
);

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sys_reset_req, sys_off_req;

  int checks = 0;
  int errors = 0;
  logic w_rst1, w_off1, w_rsp1, w_rst2, w_off2;

  always #4 clk = ~clk;

  sysctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sys_reset_req(sys_reset_req), .sys_off_req(sys_off_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    w_rst1 = sys_reset_req; w_off1 = sys_off_req; w_rsp1 = rsp_valid;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    @(posedge clk); #1;
    w_rst2 = sys_reset_req; w_off2 = sys_off_req;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); #1;
    check("R4 rsp_valid after read", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    check("R4 rsp_valid idle", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 reset_req cleared", {31'b0, sys_reset_req}, 32'd0);
    check("R10 off_req cleared", {31'b0, sys_off_req}, 32'd0);
    check("R10 rsp_valid cleared", {31'b0, rsp_valid}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_values();
    logic [31:0] v;
    check("R4 ready high", {31'b0, req_ready}, 32'd1);
    do_read(12'h100, v); check("R1 0x100", v, 32'h35F2_0121);
    do_read(12'h104, v); check("R1 0x104", v, 32'h0000_0002);
    do_read(12'h108, v); check("R1 0x108", v, 32'h35F3_0121);
    do_read(12'h10C, v); check("R1 0x10C", v, 32'h35F4_0121);
    do_read(12'h000, v); check("R2 0x000", v, 32'h0);
    do_read(12'h110, v); check("R2 0x110", v, 32'h0);
    do_read(12'hF00, v); check("R2 0xF00", v, 32'h0);
    do_read(12'hFFC, v); check("R2 0xFFC", v, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    do_write(12'h004, 32'hA5A5_0001);
    check("R4 no rsp on write", {31'b0, w_rsp1}, 32'd0);
    do_read(12'h004, v); check("R3 0x004", v, 32'hA5A5_0001);
    do_write(12'h203, 32'h1357_9BDF);
    do_read(12'h200, v); check("R3 low bits on write", v, 32'h1357_9BDF);
    do_read(12'h201, v); check("R3 low bits on read", v, 32'h1357_9BDF);
    do_write(12'hFFC, 32'hDEAD_BEEF);
    do_read(12'hFFE, v); check("R3 top word", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_forcing();
    logic [31:0] v;
    do_write(12'h100, 32'h0);
    do_read(12'h100, v); check("R5 0x100 forced", v, 32'h3000_0000);
    do_write(12'h104, 32'h0);
    do_read(12'h104, v); check("R5 0x104 unforced", v, 32'h0);
    do_write(12'h108, 32'h0000_1234);
    do_read(12'h108, v); check("R5 0x108 forced", v, 32'h3000_1234);
    do_write(12'h10C, 32'hFFFF_FFFF);
    do_read(12'h10C, v); check("R5 0x10C forced", v, 32'hFFFF_FFFF);
    do_write(12'h110, 32'h0);
    do_read(12'h110, v); check("R5 0x110 unforced", v, 32'h0);
  endtask

  task automatic t_commands();
    logic [31:0] v;
    do_write(12'hF00, 32'd1);
    check("R6 code 1 reset", {31'b0, w_rst1}, 32'd1);
    check("R9 code 1 no off", {31'b0, w_off1}, 32'd0);
    check("R9 code 1 pulse ends", {30'b0, w_rst2, w_off2}, 32'd0);
    do_write(12'hF02, 32'd2);
    check("R6 code 2 reset", {31'b0, w_rst1}, 32'd1);
    check("R9 code 2 pulse ends", {30'b0, w_rst2, w_off2}, 32'd0);
    do_write(12'hF00, 32'd3);
    check("R7 code 3 off", {31'b0, w_off1}, 32'd1);
    check("R9 code 3 no reset", {31'b0, w_rst1}, 32'd0);
    check("R9 code 3 pulse ends", {30'b0, w_rst2, w_off2}, 32'd0);
    do_read(12'hF00, v); check("R8 code stored", v, 32'd3);
    do_write(12'hF00, 32'd0);
    check("R8 code 0 none", {30'b0, w_rst1, w_off1}, 32'd0);
    do_write(12'hF00, 32'd4);
    check("R8 code 4 none", {30'b0, w_rst1, w_off1}, 32'd0);
    do_write(12'hF00, 32'h101);
    check("R8 code 0x101 none", {30'b0, w_rst1, w_off1}, 32'd0);
    do_read(12'hF00, v); check("R8 other value stored", v, 32'h101);
    do_write(12'hF04, 32'd1);
    check("R8 other offset none", {30'b0, w_rst1, w_off1}, 32'd0);
    do_write(12'hEFC, 32'd3);
    check("R8 other offset code 3 none", {30'b0, w_rst1, w_off1}, 32'd0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'hF00; req_wdata = 32'd1;
    @(posedge clk); #1;
    check("R9 b2b first reset", {30'b0, sys_reset_req, sys_off_req}, 32'd2);
    @(negedge clk);
    req_wdata = 32'd3;
    @(posedge clk); #1;
    check("R9 b2b then off", {30'b0, sys_reset_req, sys_off_req}, 32'd1);
    @(negedge clk);
    req_wdata = 32'd2;
    @(posedge clk); #1;
    check("R9 b2b then reset", {30'b0, sys_reset_req, sys_off_req}, 32'd2);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    @(posedge clk); #1;
    check("R9 b2b idle", {30'b0, sys_reset_req, sys_off_req}, 32'd0);
  endtask

  task automatic t_reset_restore();
    logic [31:0] v;
    do_write(12'h104, 32'h55);
    do_write(12'h020, 32'h77);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'hF00; req_wdata = 32'd3;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
    check("R7 off before reset", {31'b0, sys_off_req}, 32'd1);
    apply_reset();
    do_read(12'h104, v); check("R10 0x104 restored", v, 32'h2);
    do_read(12'h100, v); check("R10 0x100 restored", v, 32'h35F2_0121);
    do_read(12'h020, v); check("R10 0x020 cleared", v, 32'h0);
    do_read(12'hF00, v); check("R10 cmd word cleared", v, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset_req at reset", {31'b0, sys_reset_req}, 32'd0);
    check("R10 off_req at reset", {31'b0, sys_off_req}, 32'd0);
    check("R4 rsp_valid at reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    t_reset_values();
    t_readback();
    t_forcing();
    t_commands();
    t_back_to_back();
    t_reset_restore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule